// File: doc/BRIEF.md
# Serial Register Access Port

This block gives a host processor access to a small bank of eight byte-wide registers over a single serial data line. The host places a 3-bit register index on parallel address inputs and moves the data with its own shift clock. Active-low read and write strobes frame each access. Data travels least significant bit first in both directions.

Six of the registers hold control settings. They are written by the host and presented in parallel to the rest of the chip. The remaining two mirror status inputs from internal monitors and cannot be changed by the host. All host signals are sampled by the block's system clock, which must run several times faster than the shift clock. Every shift-clock level and strobe level is held for at least two system-clock cycles.

The serial data has no flow control. The host paces every bit with the shift clock, so the block offers no valid/ready handshake. Instead, a read drives an output-enable alongside the data line, and the host releases the bus by raising the read strobe.

Top module: `serial_reg_port`

## Requirements
- R1: During and after reset, all six control registers read as zero and the data output enable is low.
- R2: A falling edge of the read strobe snapshots the register selected by the address and raises the output enable. The data output then shows bit 0. Each later shift-clock falling edge advances the output to the next more significant bit, so the host reads the byte LSB first on shift-clock rising edges.
- R3: After the eighth shift-clock falling edge of a read, the output enable drops low, even while the read strobe stays low.
- R4: A rising edge of the read strobe ends a read at once, whatever the bit count. The output enable is low from the next system-clock cycle.
- R5: While the read strobe is high, each shift-clock rising edge shifts the data input into a holding byte from the top, so that after eight edges the first bit sent sits at bit 0. A rising edge of the write strobe copies the holding byte into the addressed control register.
- R6: Write commits to address 6 or 7 leave every register unchanged.
- R7: Address 6 reads the detect status input and address 7 reads the identity status input, as registered one system-clock cycle earlier. Host writes never alter them.
- R8: The address is used at the read strobe's falling edge and at the write strobe's rising edge. Control register n appears on bits [8n+7:8n] of the parallel control output.
- R9: When more than eight bits are shifted in before a commit, only the last eight are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Host shift clock |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register index |
| sdi | input | 1 | Serial write data |
| sdo | output | 1 | Serial read data, zero when not enabled |
| sdo_oe | output | 1 | Output enable for the serial read data |
| det_status | input | 8 | Detect monitor value (register 6) |
| id_status | input | 8 | Identity monitor value (register 7) |
| ctrl_regs | output | 48 | Parallel view of control registers 0 to 5 |

## Verification
A corrupted holding byte or control register only becomes visible on the parallel control output one cycle after a commit. Through the serial line, it shows up on the next read of that address. A bit counter that is off shifts every later read byte or leaves the output enable high past the eighth bit. The reference model compares the enable and data every system clock, so such an error is caught within the cycle it appears. Abort handling and read-only protection are checked by watching the enable right after the strobe rises, and the control output right after a commit to the status addresses.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int REG_W  = 8;
  localparam int N_REGS = 8;
  localparam int N_CTRL = 6;
  localparam int ADDR_W = $clog2(N_REGS);
  typedef logic [REG_W-1:0] byte_t;
endpackage

// File: rtl/srp_edge.sv
module srp_edge #(
  parameter int  N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[g] <= RST_VAL[g];
      else        lvl_q[g] <= lvl[g];
    end
    assign rise[g] =  lvl[g] & ~lvl_q[g];
    assign fall[g] = ~lvl[g] &  lvl_q[g];
  end
endmodule

// File: rtl/srp_bank.sv
module srp_bank
  import srp_pkg::*;
#(
  parameter int W      = REG_W,
  parameter int NREG   = N_REGS,
  parameter int NCTRL  = N_CTRL,
  parameter int AW     = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            commit,
  input  logic [W-1:0]    wdata,
  input  logic [W-1:0]    det_status,
  input  logic [W-1:0]    id_status,
  output logic [W-1:0]    rdata,
  output logic [NCTRL*W-1:0] ctrl_flat
);
  localparam int DET_IDX = NCTRL;
  localparam int ID_IDX  = NCTRL + 1;

  logic [W-1:0] ctrl_q [NCTRL];
  logic [W-1:0] det_q, id_q;

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q[g] <= '0;
      else if (commit && (int'(addr) == g)) ctrl_q[g] <= wdata;
    end
    assign ctrl_flat[g*W +: W] = ctrl_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_q <= '0;
      id_q  <= '0;
    end else begin
      det_q <= det_status;
      id_q  <= id_status;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) == DET_IDX)      rdata = det_q;
    else if (int'(addr) == ID_IDX)  rdata = id_q;
    else begin
      for (int i = 0; i < NCTRL; i++)
        if (int'(addr) == i) rdata = ctrl_q[i];
    end
  end

  // R5
  ctrl_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl_flat));

  // R6
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && int'(addr) >= NCTRL) |=> $stable(ctrl_flat));
endmodule

// File: rtl/srp_shift.sv
module srp_shift
  import srp_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_lvl_n,
  input  logic         rd_fall,
  input  logic         rd_rise,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         sdi,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] hold,
  output logic         sdo,
  output logic         sdo_oe
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  out_sh;
  logic [CW-1:0] bit_cnt;
  logic          oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (sclk_rise && rd_lvl_n) begin
      hold <= {sdi, hold[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sh  <= '0;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (rd_fall) begin
      out_sh  <= load_data;
      bit_cnt <= '0;
      oe_q    <= 1'b1;
    end else if (rd_rise) begin
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (oe_q && sclk_fall) begin
      out_sh  <= out_sh >> 1;
      bit_cnt <= bit_cnt + 1'b1;
      if (int'(bit_cnt) == W - 1) oe_q <= 1'b0;
    end
  end

  assign sdo_oe = oe_q;
  assign sdo    = oe_q & out_sh[0];

  // R4
  abort_drops_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !sdo_oe);

  // R3
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (int'(bit_cnt) < W));

  // R2
  sdo_holds_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !sclk_fall && !rd_rise && !rd_fall) |=> $stable(sdo));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic [REG_W-1:0]      det_status,
  input  logic [REG_W-1:0]      id_status,
  output logic [N_CTRL*REG_W-1:0] ctrl_regs
);
  localparam int NSIG = 3;
  localparam int I_SCLK = 0;
  localparam int I_RD   = 1;
  localparam int I_WR   = 2;

  logic [NSIG-1:0] lvl, rise, fall;
  logic [REG_W-1:0] hold, rdata;

  assign lvl = {wr_n, rd_n, sclk};

  srp_edge #(.N(NSIG), .RST_VAL(3'b110)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
  );

  srp_shift #(.W(REG_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .rd_lvl_n(rd_n),
    .rd_fall(fall[I_RD]), .rd_rise(rise[I_RD]),
    .sclk_rise(rise[I_SCLK]), .sclk_fall(fall[I_SCLK]),
    .sdi(sdi), .load_data(rdata), .hold(hold),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  srp_bank #(.W(REG_W), .NREG(N_REGS), .NCTRL(N_CTRL), .AW(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .commit(rise[I_WR]), .wdata(hold),
    .det_status(det_status), .id_status(id_status),
    .rdata(rdata), .ctrl_flat(ctrl_regs)
  );

  // R1
  oe_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && $past(rd_n)) |-> !sdo_oe);
endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, rd_n = 1'b1, wr_n = 1'b1, sdi = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] det_status = '0, id_status = '0;
  logic sdo, sdo_oe;
  logic [47:0] ctrl_regs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_reg_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .det_status(det_status), .id_status(id_status), .ctrl_regs(ctrl_regs)
  );

  // Behavioural reference model, updated on every rising clock.
  logic [7:0] m_ctrl [6];
  logic [7:0] m_det, m_id, m_hold, m_out;
  logic       m_oe;
  int         m_bits;
  logic       p_sclk, p_rd, p_wr;

  function automatic logic [7:0] m_read(input int a);
    if (a == 6) return m_det;
    if (a == 7) return m_id;
    return m_ctrl[a];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_ctrl[i]) m_ctrl[i] = '0;
      m_det = '0; m_id = '0; m_hold = '0; m_out = '0;
      m_oe = 1'b0; m_bits = 0;
      p_sclk = 1'b0; p_rd = 1'b1; p_wr = 1'b1;
    end else begin
      if (p_rd && !rd_n) begin
        m_out = m_read(int'(addr)); m_oe = 1'b1; m_bits = 0;
      end else if (!p_rd && rd_n) begin
        m_oe = 1'b0; m_bits = 0;
      end else if (m_oe && p_sclk && !sclk) begin
        m_out = {1'b0, m_out[7:1]}; m_bits++;
        if (m_bits == 8) m_oe = 1'b0;
      end
      if (!p_wr && wr_n && addr < 3'd6) m_ctrl[addr] = m_hold;
      if (!p_sclk && sclk && rd_n) m_hold = {sdi, m_hold[7:1]};
      m_det = det_status; m_id = id_status;
      p_sclk = sclk; p_rd = rd_n; p_wr = wr_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [47:0] exp_flat;
      for (int i = 0; i < 6; i++) exp_flat[i*8 +: 8] = m_ctrl[i];
      checks++;
      if (sdo_oe !== m_oe || sdo !== (m_oe & m_out[0])) begin
        errors++;
        $display("FAIL R2 model: oe/sdo %b%b expected %b%b", sdo_oe, sdo, m_oe, m_oe & m_out[0]);
      end
      checks++;
      if (ctrl_regs !== exp_flat) begin
        errors++;
        $display("FAIL R5 model: ctrl %h expected %h", ctrl_regs, exp_flat);
      end
    end
  end

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_bits(input logic [2:0] a, input int n, input logic [15:0] d);
    rd_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      sdi = d[i]; sclk = 1'b1; step(2); sclk = 1'b0; step(2);
    end
    addr = a; wr_n = 1'b0; step(2); wr_n = 1'b1; step(2);
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_n = 1'b0; step(2);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; step(2); v[i] = sdo; sclk = 1'b0; step(2);
    end
    check("R3 oe after eighth bit", {47'd0, sdo_oe}, 48'd0);
    rd_n = 1'b1; step(2);
  endtask

  initial begin
    logic [7:0] v;
    step(4); rst_n = 1'b1; step(2);
    check("R1 reset ctrl", ctrl_regs, 48'd0);
    check("R1 reset oe", {47'd0, sdo_oe}, 48'd0);

    write_bits(3'd0, 8, 16'h00A5);
    write_bits(3'd5, 8, 16'h003C);
    check("R8 ctrl field 0", {40'd0, ctrl_regs[7:0]}, 48'hA5);
    check("R8 ctrl field 5", {40'd0, ctrl_regs[47:40]}, 48'h3C);
    read_reg(3'd0, v); check("R2 read addr 0", {40'd0, v}, 48'hA5);
    read_reg(3'd5, v); check("R5 read addr 5", {40'd0, v}, 48'h3C);

    det_status = 8'h12; id_status = 8'h9A;
    write_bits(3'd6, 8, 16'h00FF);
    write_bits(3'd7, 8, 16'h0000);
    check("R6 ctrl unchanged", ctrl_regs, {8'h3C, 32'd0, 8'hA5});
    read_reg(3'd6, v); check("R7 detect", {40'd0, v}, 48'h12);
    read_reg(3'd7, v); check("R7 id", {40'd0, v}, 48'h9A);
    det_status = 8'h55; step(2);
    read_reg(3'd6, v); check("R7 detect follows", {40'd0, v}, 48'h55);

    write_bits(3'd2, 10, 16'h02D6);
    read_reg(3'd2, v); check("R9 last eight bits", {40'd0, v}, 48'hB5);

    addr = 3'd0; rd_n = 1'b0; step(2);
    check("R2 oe after strobe", {47'd0, sdo_oe}, 48'd1);
    check("R2 first bit", {47'd0, sdo}, 48'd1);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; step(2); sclk = 1'b0; step(2);
    end
    rd_n = 1'b1; step(1);
    check("R4 abort", {47'd0, sdo_oe}, 48'd0);
    step(1);
    read_reg(3'd0, v); check("R4 read after abort", {40'd0, v}, 48'hA5);

    for (int i = 0; i < 6; i++) write_bits(3'(i), 8, 16'(i * 8'h11 + 1));
    for (int i = 0; i < 6; i++) begin
      read_reg(3'(i), v); check("R8 address select", {40'd0, v}, 48'(i * 8'h11 + 1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule